// File: doc/BRIEF.md
# Physical address cacheability classifier

This pipeline stage sits after address translation. It takes a physical address, plus a flag that marks the access as an instruction fetch. One cycle later it reports whether the access must bypass the caches. It also gives the address to send on to memory and raises one of two fault indications.

A single high address bit marks the uncached region. An elaboration parameter places that bit at position 43 (wide layout) or position 39 (narrow layout).

Some uncached addresses fall in an internal-register window, which this block does not implement. Such an address raises a register-space fault instead of being classified. An uncached instruction fetch is refused, because a device read can destroy state.

In the wide layout, an uncached address is compacted by zeroing a field of bits before it is passed on. The memory system and the handling of the faults are outside this block.

Top module: `paddr_classifier`

## Requirements
- R1: With `NARROW_LAYOUT`=0, an address is uncached exactly when bit 43 is set. Bit 39 plays no part in that decision.
- R2: With `NARROW_LAYOUT`=1, an address is uncached exactly when bit 39 is set. Bit 43 plays no part in that decision.
- R3: An address whose uncached bit is clear is passed on unchanged. `out_uncached` is low and both fault outputs are low.
- R4: In the wide layout, an uncached address that is not in the register window leaves with bits 42:35 forced to zero and all other bits unchanged. In the narrow layout, the address is passed on unchanged.
- R5: An address whose uncached bit is set and whose bits 42:40 equal 3'b111 sets `out_fault_regspace`. For that address, `out_uncached` and `out_fault_fetch_io` are low and the address is passed on unchanged.
- R6: An uncached address outside the register window sets `out_fault_fetch_io` when `in_ifetch` is 1 and leaves it low when `in_ifetch` is 0.
- R7: `out_valid` equals `in_valid` delayed by one clock. The data outputs of that cycle describe the address presented with it.
- R8: A cycle with `in_valid` low leaves `out_paddr`, `out_uncached` and both faults unchanged on the next cycle.
- R9: After synchronous reset, `out_valid`, `out_paddr`, `out_uncached` and both faults are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input address is present |
| in_paddr | input | 44 | Translated physical address |
| in_ifetch | input | 1 | Access is an instruction fetch |
| out_valid | output | 1 | Registered result is present |
| out_paddr | output | 44 | Address to pass on (possibly compacted) |
| out_uncached | output | 1 | Access must bypass the caches |
| out_fault_regspace | output | 1 | Unimplemented register window addressed |
| out_fault_fetch_io | output | 1 | Instruction fetch from uncached space |

## Verification
The register-window fault and the fetch-from-I/O fault can be provoked in the same cycle. This happens when an instruction fetch targets the register window. The bench sweeps every combination of bits 43:35 with the fetch flag both low and high. In each such collision, exactly one fault must appear, namely the register fault. Neither the uncached flag nor the compaction may show through. The same sweep also drives instances of both layouts at once, so an address that is uncached in one layout and cacheable in the other is judged against both expectations.

// File: rtl/paddr_cls_pkg.sv
package paddr_cls_pkg;
    localparam int PA_W      = 44;
    localparam int WIDE_POS  = 43;
    localparam int NARR_POS  = 39;
    localparam int WIN_HI    = 42;
    localparam int WIN_LO    = 40;
    localparam int SQZ_HI    = 42;
    localparam int SQZ_LO    = 35;

    typedef logic [PA_W-1:0] paddr_t;

    typedef struct packed {
        paddr_t paddr;
        logic   uncached;
        logic   flt_reg;
        logic   flt_fetch;
    } cls_res_t;

    function automatic int uc_position(bit narrow);
        return narrow ? NARR_POS : WIDE_POS;
    endfunction

    function automatic paddr_t squeeze_mask();
        paddr_t m = '0;
        for (int b = SQZ_LO; b <= SQZ_HI; b++) m[b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/uc_region_detect.sv
module uc_region_detect
    import paddr_cls_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  paddr_t paddr,
    output logic   is_uc,
    output logic   in_window
);
    localparam int UC_POS = uc_position(NARROW);

    always_comb begin
        is_uc     = paddr[UC_POS];
        in_window = is_uc && (paddr[WIN_HI:WIN_LO] == 3'b111);
    end
endmodule

// File: rtl/addr_squeeze.sv
module addr_squeeze
    import paddr_cls_pkg::*;
#(
    parameter bit SQUEEZE = 1'b1
) (
    input  paddr_t paddr,
    input  logic   apply,
    output paddr_t paddr_out
);
    localparam paddr_t MASK = SQUEEZE ? squeeze_mask() : '0;

    always_comb paddr_out = apply ? (paddr & ~MASK) : paddr;
endmodule

// File: rtl/cls_stage_reg.sv
module cls_stage_reg
    import paddr_cls_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     v_in,
    input  cls_res_t d_in,
    output logic     v_out,
    output cls_res_t d_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            d_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) d_out <= d_in;
        end
    end
endmodule

// File: rtl/paddr_classifier.sv
module paddr_classifier
    import paddr_cls_pkg::*;
#(
    parameter bit NARROW_LAYOUT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [PA_W-1:0] in_paddr,
    input  logic            in_ifetch,
    output logic            out_valid,
    output logic [PA_W-1:0] out_paddr,
    output logic            out_uncached,
    output logic            out_fault_regspace,
    output logic            out_fault_fetch_io
);
    logic     is_uc, in_win, uc_plain;
    paddr_t   sq_addr;
    cls_res_t nxt, cur;

    uc_region_detect #(.NARROW(NARROW_LAYOUT)) u_det (
        .paddr(in_paddr), .is_uc(is_uc), .in_window(in_win)
    );

    assign uc_plain = is_uc & ~in_win;

    addr_squeeze #(.SQUEEZE(!NARROW_LAYOUT)) u_sqz (
        .paddr(in_paddr), .apply(uc_plain), .paddr_out(sq_addr)
    );

    always_comb begin
        nxt.paddr     = sq_addr;
        nxt.uncached  = uc_plain;
        nxt.flt_reg   = in_win;
        nxt.flt_fetch = uc_plain & in_ifetch;
    end

    cls_stage_reg u_reg (
        .clk(clk), .rst(rst), .v_in(in_valid), .d_in(nxt),
        .v_out(out_valid), .d_out(cur)
    );

    assign out_paddr          = cur.paddr;
    assign out_uncached       = cur.uncached;
    assign out_fault_regspace = cur.flt_reg;
    assign out_fault_fetch_io = cur.flt_fetch;

    // R5
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_fault_regspace, out_fault_fetch_io}));
    // R5
    win_not_uc_chk: assert property (@(posedge clk) disable iff (rst)
        out_fault_regspace |-> !out_uncached);
    // R6
    fetch_needs_uc_chk: assert property (@(posedge clk) disable iff (rst)
        out_fault_fetch_io |-> out_uncached);
    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R7
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_paddr) && $stable(out_uncached));

    generate
        if (!NARROW_LAYOUT) begin : g_wide_chk
            // R4
            squeeze_chk: assert property (@(posedge clk) disable iff (rst)
                out_uncached |-> (out_paddr[SQZ_HI:SQZ_LO] == '0));
        end
    endgenerate
endmodule

// File: tb/sim_paddr_classifier.sv
module sim_paddr_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 44;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [AW-1:0] in_paddr = '0;
    logic in_ifetch = 1'b0;

    logic w_valid, w_uc, w_freg, w_ffet;
    logic [AW-1:0] w_addr;
    logic n_valid, n_uc, n_freg, n_ffet;
    logic [AW-1:0] n_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    paddr_classifier #(.NARROW_LAYOUT(1'b0)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_paddr(in_paddr),
        .in_ifetch(in_ifetch), .out_valid(w_valid), .out_paddr(w_addr),
        .out_uncached(w_uc), .out_fault_regspace(w_freg), .out_fault_fetch_io(w_ffet));

    paddr_classifier #(.NARROW_LAYOUT(1'b1)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_paddr(in_paddr),
        .in_ifetch(in_ifetch), .out_valid(n_valid), .out_paddr(n_addr),
        .out_uncached(n_uc), .out_fault_regspace(n_freg), .out_fault_fetch_io(n_ffet));

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic judge(input bit narrow, input logic [AW-1:0] a, input bit f,
                         input logic ov, input logic [AW-1:0] oa,
                         input logic ou, input logic ofr, input logic off);
        bit uc, win, plain;
        logic [AW-1:0] ea;
        uc  = narrow ? a[39] : a[43];
        win = uc && (a[42:40] == 3'b111);
        plain = uc && !win;
        ea = a;
        if (plain && !narrow) ea[42:35] = 8'h00;
        chk("R7 valid", AW'(ov), AW'(1));
        if (!uc) begin
            chk("R3 addr", oa, a);
            chk("R3 flags", AW'({ou, ofr, off}), AW'(0));
        end else if (win) begin
            chk("R5 flags", AW'({ou, ofr, off}), AW'(3'b010));
            chk("R5 addr", oa, a);
        end else begin
            chk(narrow ? "R2 uncached" : "R1 uncached", AW'(ou), AW'(1));
            chk("R4 addr", oa, ea);
            chk("R6 fetch fault", AW'(off), AW'(f));
            chk("R5 no reg fault", AW'(ofr), AW'(0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 wide", {w_valid, w_uc, w_freg, w_ffet} == 0 && w_addr == 0 ? AW'(0) : AW'(1), AW'(0));
        chk("R9 narrow", {n_valid, n_uc, n_freg, n_ffet} == 0 && n_addr == 0 ? AW'(0) : AW'(1), AW'(0));
        rst = 1'b0;
        for (int h = 0; h < 512; h++) begin
            for (int f = 0; f < 2; f++) begin
                logic [63:0] mix;
                logic [AW-1:0] a;
                mix = 64'(h * 2 + f) * 64'h9E3779B97F4A7C15;
                a = {h[8:0], mix[40:6]};
                @(negedge clk);
                in_valid = 1'b1;
                in_paddr = a;
                in_ifetch = f[0];
                @(negedge clk);
                judge(1'b0, a, f[0], w_valid, w_addr, w_uc, w_freg, w_ffet);
                judge(1'b1, a, f[0], n_valid, n_addr, n_uc, n_freg, n_ffet);
                if (h % 64 == 5) begin
                    logic [AW-1:0] keep_w, keep_n;
                    logic [2:0] kf;
                    keep_w = w_addr;
                    keep_n = n_addr;
                    kf = {w_uc, w_freg, w_ffet};
                    in_valid = 1'b0;
                    in_paddr = ~a;
                    in_ifetch = ~f[0];
                    @(negedge clk);
                    // R8 idle cycle holds data, R7 valid drops
                    chk("R8 hold wide", w_addr, keep_w);
                    chk("R8 hold narrow", n_addr, keep_n);
                    chk("R8 hold flags", AW'({w_uc, w_freg, w_ffet}), AW'(kf));
                    chk("R7 valid low", AW'({w_valid, n_valid}), AW'(0));
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule